// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Partial Flags

This block is a first-in first-out buffer of byte-wide words. It has a write port and a read port, and each port runs on its own clock. The two clocks may be unrelated, or they may be the same net. Each port has an active-low enable. The read port loads the oldest word into an output register, which keeps its value until the next accepted read. An active-low output enable is carried to a separate drive-enable output and does not disturb the register.

Four active-low status flags report occupancy. Empty and almost-empty are generated in the read clock domain. Full and almost-full are generated in the write clock domain. The partial flags sit seven words in from each boundary.

Pointers cross between the domains in Gray code through two-stage synchronizers. As a result, a flag reacts at once to activity on its own port but only a few cycles later to activity on the other port, and it always errs on the safe side. A parameter removes the synchronizers when both clocks are one net. Depth is a power-of-two parameter from 64 to 4096 words.

Top module: `byte_fifo_dc`

## Requirements
- R1: A word presented on `wr_data` is stored on a rising `wr_clk` edge when `wr_en_n` is low and `full_n` is high. Stored words leave on `rd_data` in the order they were written.
- R2: While `full_n` is low, a low `wr_en_n` stores nothing and the write pointer does not advance.
- R3: On a rising `rd_clk` edge with `rd_en_n` low and `empty_n` high, the oldest word is loaded into `rd_data`. While `rd_en_n` is high, `rd_data` keeps its value.
- R4: While `empty_n` is low, a low `rd_en_n` changes neither `rd_data` nor the read pointer.
- R5: While `rst_n` is low, both pointers return to location zero and `rd_data` becomes 0x00. `empty_n` and `aempty_n` are driven low, and `full_n` and `afull_n` are driven high. Writes presented during reset are not stored.
- R6: Once both ports have been idle for a few cycles, the flags follow the word count N out of depth D. When N=0, `empty_n` and `aempty_n` are low. When 1≤N≤7, only `aempty_n` is low. When 8≤N≤D-8, all four flags are high. When D-7≤N≤D-1, only `afull_n` is low. When N=D, `full_n` and `afull_n` are low.
- R7: The flags are conservative. `empty_n` is high only when at least one word is stored, and `full_n` is high only when at least one location is free.
- R8: `empty_n` and `aempty_n` change only on `rd_clk` edges, and `full_n` and `afull_n` change only on `wr_clk` edges. Each pointer crosses to the other domain as a Gray code that changes at most one bit per edge.
- R9: `rd_dv` is high exactly when `oe_n` is low, and `oe_n` has no effect on the value held in `rd_data`.
- R10: A low `full_n` is always accompanied by a low `afull_n`, and a low `empty_n` is always accompanied by a low `aempty_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DW (8) | Word to store |
| rd_en_n | input | 1 | Active-low read enable |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | DW (8) | Output register holding the last word read |
| rd_dv | output | 1 | High when the output bus is to be driven |
| full_n | output | 1 | Low when no location is free (write domain) |
| afull_n | output | 1 | Low when seven or fewer locations are free (write domain) |
| empty_n | output | 1 | Low when no word is stored (read domain) |
| aempty_n | output | 1 | Low when seven or fewer words are stored (read domain) |

## Verification
The assertions take three things for granted. Enables and data are stable around each rising edge of their own clock. Reset is held low for at least two edges of each clock before it is released. The enables carry defined levels whenever reset is high. The stimulus changes every input on a falling edge of the matching clock and holds reset across several cycles of both clocks. Exact flag values are compared only after both ports have idled longer than the synchronizer delay. During free-running traffic the comparison against the queue model is limited to the safe direction of each flag.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  // Distance of each partial flag from its boundary, in words
  localparam int AFLAG_GAP = 7;
  // Narrowest and widest supported depths
  localparam int MIN_DEPTH = 64;
  localparam int MAX_DEPTH = 4096;
endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/fifo_sync_bus.sv
module fifo_sync_bus #(
  parameter int W      = 10,
  parameter bit BYPASS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (BYPASS) begin : g_thru
    logic unused_ok;
    assign unused_ok = clk ^ rst_n;
    assign q = d;
  end else begin : g_two_ff
    logic [W-1:0] s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= '0;
        s2_q <= '0;
      end else begin
        s1_q <= d;
        s2_q <= s1_q;
      end
    end
    assign q = s2_q;
  end
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [PW-1:0] rgray_s,
  output logic          wr_ok,
  output logic [PW-1:0] wptr_bin,
  output logic [PW-1:0] wptr_gray,
  output logic          full_n,
  output logic          afull_n
);
  logic [PW-1:0] wptr_q, wptr_nxt, wgray_q, wgray_nxt, rbin_s, count_nxt;
  logic          full_nxt, afull_nxt;

  // Convert the synchronized Gray read pointer back to binary
  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  always_comb begin
    wr_ok     = !wr_en_n && full_n;
    wptr_nxt  = wptr_q + PW'(wr_ok);
    wgray_nxt = wptr_nxt ^ (wptr_nxt >> 1);
    count_nxt = wptr_nxt - rbin_s;
    full_nxt  = (count_nxt != PW'(DEPTH));
    afull_nxt = (count_nxt < PW'(DEPTH - AFLAG_GAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_q <= wgray_nxt;
      full_n  <= full_nxt;
      afull_n <= afull_nxt;
    end
  end

  assign wptr_bin  = wptr_q;
  assign wptr_gray = wgray_q;
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
  import byte_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 512,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic [PW-1:0] wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [PW-1:0] rptr_bin,
  output logic [PW-1:0] rptr_gray,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n
);
  logic [PW-1:0] rptr_q, rptr_nxt, rgray_q, rgray_nxt, wbin_s, count_nxt;
  logic [DW-1:0] data_nxt;
  logic          rd_ok, empty_nxt, aempty_nxt;

  // Convert the synchronized Gray write pointer back to binary
  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  always_comb begin
    rd_ok      = !rd_en_n && empty_n;
    rptr_nxt   = rptr_q + PW'(rd_ok);
    rgray_nxt  = rptr_nxt ^ (rptr_nxt >> 1);
    count_nxt  = wbin_s - rptr_nxt;
    empty_nxt  = (count_nxt != '0);
    aempty_nxt = (count_nxt > PW'(AFLAG_GAP));
    data_nxt   = rd_ok ? mem_q : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q   <= '0;
      rgray_q  <= '0;
      rd_data  <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rptr_q   <= rptr_nxt;
      rgray_q  <= rgray_nxt;
      rd_data  <= data_nxt;
      empty_n  <= empty_nxt;
      aempty_n <= aempty_nxt;
    end
  end

  assign rptr_bin  = rptr_q;
  assign rptr_gray = rgray_q;
endmodule

// File: rtl/byte_fifo_dc.sv
module byte_fifo_dc
  import byte_fifo_pkg::*;
#(
  parameter int DW         = 8,
  parameter int DEPTH      = 512,
  parameter bit SINGLE_CLK = 1'b0
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_dv,
  output logic          full_n,
  output logic          afull_n,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  initial begin
    if (DEPTH < MIN_DEPTH || DEPTH > MAX_DEPTH || (1 << AW) != DEPTH)
      $error("byte_fifo_dc: DEPTH must be a power of two in range");
  end

  logic          wr_rst_n, rd_rst_n, wr_ok;
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wgray_s, rgray_s;
  logic [DW-1:0] mem_q;

  fifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n));
  fifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n));

  fifo_sync_bus #(.W(PW), .BYPASS(SINGLE_CLK)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wgray_s)
  );
  fifo_sync_bus #(.W(PW), .BYPASS(SINGLE_CLK)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rgray_s)
  );

  fifo_wr_ctl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_en_n(wr_en_n), .rgray_s(rgray_s),
    .wr_ok(wr_ok), .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
    .full_n(full_n), .afull_n(afull_n)
  );

  fifo_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(wr_ok), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
    .raddr(rptr_bin[AW-1:0]), .rdata(mem_q)
  );

  fifo_rd_ctl #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_en_n(rd_en_n), .wgray_s(wgray_s),
    .mem_q(mem_q), .rptr_bin(rptr_bin), .rptr_gray(rptr_gray),
    .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  assign rd_dv = !oe_n;
endmodule

// File: rtl/byte_fifo_dc_chk.sv
module byte_fifo_dc_chk #(
  parameter int DW = 8,
  parameter int PW = 10
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic [DW-1:0] rd_data,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin,
  input logic [PW-1:0] wptr_gray,
  input logic [PW-1:0] rptr_gray
);
  // R2
  wr_when_full_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && !wr_en_n) |=> $stable(wptr_bin));

  // R4
  rd_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !rd_en_n) |=> ($stable(rptr_bin) && $stable(rd_data)));

  // R3
  out_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_en_n |=> $stable(rd_data));

  // R8
  wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  // R8
  rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

  // R10
  full_nest_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R10
  empty_nest_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
endmodule

bind byte_fifo_dc byte_fifo_dc_chk #(.DW(DW), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wptr_bin(wptr_bin), .rptr_bin(rptr_bin),
  .wptr_gray(wptr_gray), .rptr_gray(rptr_gray)
);

// File: tb/byte_fifo_dc_test.sv
`timescale 1ns/1ps
module byte_fifo_dc_test;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int D          = 64;

  logic       wr_clk = 1'b0, rd_clk = 1'b0;
  logic       rst_n = 1'b0, wr_en_n = 1'b1, rd_en_n = 1'b1, oe_n = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rd_dv, full_n, afull_n, empty_n, aempty_n;

  logic [7:0] q[$];
  int         n_cmp = 0, n_bad = 0;
  bit         mon_on = 1'b0;

  byte_fifo_dc #(.DW(8), .DEPTH(D), .SINGLE_CLK(1'b0)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .rd_data(rd_data), .rd_dv(rd_dv), .full_n(full_n), .afull_n(afull_n),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  // R7: safe-direction flag checks on every clock while traffic runs
  always @(posedge rd_clk) begin
    #1;
    if (mon_on) chk(!(empty_n && q.size() == 0), "R7", "empty_n high with no data",
                    int'(empty_n), 0);
  end
  always @(posedge wr_clk) begin
    #1;
    if (mon_on) chk(!(full_n && q.size() >= D), "R7", "full_n high with no space",
                    int'(full_n), 0);
  end

  task automatic settle();
    repeat (5) @(negedge wr_clk);
    repeat (5) @(negedge rd_clk);
  endtask

  // R6: expected flags for a given count
  task automatic check_flags(input int n, input string req);
    chk(empty_n  == (n != 0),     req, $sformatf("empty_n at N=%0d", n),  int'(empty_n),  int'(n != 0));
    chk(aempty_n == (n >= 8),     req, $sformatf("aempty_n at N=%0d", n), int'(aempty_n), int'(n >= 8));
    chk(afull_n  == (n < D - 7),  req, $sformatf("afull_n at N=%0d", n),  int'(afull_n),  int'(n < D - 7));
    chk(full_n   == (n != D),     req, $sformatf("full_n at N=%0d", n),   int'(full_n),   int'(n != D));
  endtask

  task automatic write_word(input logic [7:0] d, output bit acc);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = d;
    acc = full_n;
    if (acc) q.push_back(d);
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic read_word(output bit acc, output logic [7:0] exp);
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    acc = empty_n;
    exp = 8'h00;
    if (acc && q.size() > 0) exp = q.pop_front();
    @(negedge rd_clk);
    rd_en_n = 1'b1;
  endtask

  task automatic write_burst(input int n, input int skip_pct, input logic [7:0] base);
    int sent = 0;
    logic [7:0] v = base;
    while (sent < n) begin
      @(negedge wr_clk);
      if ($urandom_range(99) >= skip_pct) begin
        wr_en_n = 1'b0;
        wr_data = v;
        if (full_n) begin
          q.push_back(v);
          v++;
          sent++;
        end
      end else wr_en_n = 1'b1;
    end
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic read_burst(input int n, input int skip_pct);
    int got = 0;
    bit pend = 1'b0;
    logic [7:0] e = 8'h00;
    while (got < n || pend) begin
      @(negedge rd_clk);
      if (pend) begin
        // R1: stream order
        chk(rd_data == e, "R1", "streamed word", int'(rd_data), int'(e));
        pend = 1'b0;
      end
      if (got < n && $urandom_range(99) >= skip_pct) begin
        rd_en_n = 1'b0;
        if (empty_n) begin
          if (q.size() == 0) chk(1'b0, "R7", "read accepted with model empty", 1, 0);
          else begin
            e = q.pop_front();
            pend = 1'b1;
            got++;
          end
        end
      end else rd_en_n = 1'b1;
    end
    rd_en_n = 1'b1;
  endtask

  initial begin
    bit acc;
    logic [7:0] e, held;

    // R5: writes presented during reset are not stored
    repeat (3) @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = 8'hA5;
    repeat (3) @(negedge wr_clk);
    wr_en_n = 1'b1;
    chk(rd_data == 8'h00, "R5", "rd_data in reset", int'(rd_data), 0);
    check_flags(0, "R5");
    rst_n = 1'b1;
    settle();
    check_flags(0, "R5");
    chk(rd_data == 8'h00, "R5", "rd_data after reset", int'(rd_data), 0);

    // R6 and R1: fill one word at a time
    for (int i = 1; i <= D; i++) begin
      write_word(8'(i + 8'h30), acc);
      chk(acc, "R1", "write accepted while filling", int'(acc), 1);
      settle();
      check_flags(i, "R6");
    end

    // R2: writes while full are dropped
    for (int i = 0; i < 4; i++) begin
      write_word(8'hEE, acc);
      chk(!acc, "R2", "full_n low on write attempt", int'(acc), 0);
    end
    settle();
    check_flags(D, "R2");

    // R3 and R6: drain one word at a time, order preserved
    for (int i = D - 1; i >= 0; i--) begin
      read_word(acc, e);
      chk(acc, "R3", "read accepted while draining", int'(acc), 1);
      chk(rd_data == e, "R3", "drained word", int'(rd_data), int'(e));
      settle();
      check_flags(i, "R6");
    end

    // R3: output register holds while read enable is high
    held = rd_data;
    settle();
    chk(rd_data == held, "R3", "hold with rd_en_n high", int'(rd_data), int'(held));

    // R4: reads while empty change nothing
    for (int i = 0; i < 4; i++) begin
      read_word(acc, e);
      chk(!acc, "R4", "empty_n low on read attempt", int'(acc), 0);
      chk(rd_data == held, "R4", "rd_data after empty read", int'(rd_data), int'(held));
    end
    write_word(8'h5C, acc);
    settle();
    read_word(acc, e);
    chk(rd_data == 8'h5C, "R4", "read pointer unmoved by empty reads", int'(rd_data), 8'h5C);
    held = rd_data;

    // R9: output enable only gates the drive indication
    @(negedge rd_clk);
    oe_n = 1'b1;
    #1;
    chk(rd_dv == 1'b0, "R9", "rd_dv with oe_n high", int'(rd_dv), 0);
    @(negedge rd_clk);
    chk(rd_data == held, "R9", "rd_data with oe_n high", int'(rd_data), int'(held));
    oe_n = 1'b0;
    #1;
    chk(rd_dv == 1'b1, "R9", "rd_dv with oe_n low", int'(rd_dv), 1);

    // R1, R7, R8: free-running traffic, two rate mixes
    mon_on = 1'b1;
    fork
      write_burst(400, 10, 8'h00);
      read_burst(400, 60);
    join
    fork
      write_burst(400, 60, 8'h80);
      read_burst(400, 5);
    join
    mon_on = 1'b0;
    settle();
    check_flags(0, "R8");

    // R5: reset in the middle of use
    for (int i = 0; i < 20; i++) write_word(8'(8'hC0 + i), acc);
    settle();
    read_word(acc, e);
    chk(rd_data == e, "R1", "word before reset", int'(rd_data), int'(e));
    @(negedge wr_clk);
    rst_n = 1'b0;
    q.delete();
    @(negedge rd_clk);
    chk(rd_data == 8'h00, "R5", "rd_data cleared by reset", int'(rd_data), 0);
    check_flags(0, "R5");
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
    check_flags(0, "R5");
    write_word(8'h3D, acc);
    settle();
    read_word(acc, e);
    chk(rd_data == 8'h3D, "R5", "first word after reset", int'(rd_data), 8'h3D);

    finish_run();
  end
endmodule